// File: doc/BRIEF.md
# Mesh Switch Route Computation Unit

This block decides, for one switch of a two-dimensional mesh network-on-chip, which output ports a packet may take next. It does not use a routing table or hard-wired dimension-order arithmetic. It reads a small per-switch configuration word instead. That word holds eight turn-permission bits, each of which says whether a packet arriving at the neighbouring switch in one direction may then turn into a perpendicular direction. It also holds two four-bit connectivity masks, one used for traffic that stays inside a partition and one used for global traffic, such as traffic to memory controllers or a shared cache. The size of the word does not grow with the mesh.

The unit first works out where the destination lies relative to the current switch. For a diagonal destination, each of the two productive directions is offered only if the matching turn is permitted one hop ahead. A straight destination gets its single direction, and an arrival gets the local port. Every mesh port is finally gated by its connectivity bit. When software clears connectivity bits on a partition's edge, local traffic is fenced in, while global traffic uses the second mask and can still cross. The routing permissions are shared by both traffic classes.

A request is sampled on a rising clock edge, and the port set is presented from a register one cycle later. The configuration word is loaded through a write-enable port.

Top module: `mesh_route_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `rsp_valid` and `rsp_ports` clear, and the configuration word returns to its default value 16'hFFCC. This default gives both masks fully connected and permits only the turns that X-first routing needs.
- R2: `rsp_valid` is high in the cycle after each edge that samples `req_valid` high and low otherwise. `rsp_ports` then holds the result for that request. Cycles without a request produce no result.
- R3: When the destination equals the current coordinates, `rsp_ports` is 5'b10000: bit 4 is the local port and no mesh port is set, whatever the configuration.
- R4: X grows toward east and Y grows toward north. For a destination on the same column, the result is north (bit 0) if the destination Y is larger and south (bit 2) if it is smaller. For a destination on the same row, the result is east (bit 1) if the destination X is larger and west (bit 3) if it is smaller. Each of these is gated by that port's connectivity bit, and no other bit is set.
- R5: For a diagonal destination, a vertical port is set only if turning into the needed horizontal direction is permitted, and a horizontal port is set only if turning into the needed vertical direction is permitted. The turn bits are: [0] north-then-east, [1] north-then-west, [2] east-then-north, [3] east-then-south, [4] south-then-east, [5] south-then-west, [6] west-then-north, [7] west-then-south. At most two ports are set.
- R6: A mesh port whose selected connectivity bit is 0 is never set. A request whose only candidates are unconnected yields 5'b00000.
- R7: `req_global` = 0 selects the local mask in word bits [11:8]. `req_global` = 1 selects the global mask in bits [15:12]. Within each mask, bit 0 is north, bit 1 east, bit 2 south and bit 3 west. The turn bits apply to both classes.
- R8: When `cfg_we` is high at a rising edge, `cfg_wdata` is loaded at that edge. A request sampled at that same edge still uses the old word, and requests sampled at later edges use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load enable for the configuration word |
| cfg_wdata | input | 16 | New configuration word (global mask, local mask, turn bits) |
| req_valid | input | 1 | Request present this cycle |
| req_global | input | 1 | 1 selects the global connectivity mask |
| cur_x | input | COORD_W | X coordinate of this switch |
| cur_y | input | COORD_W | Y coordinate of this switch |
| dst_x | input | COORD_W | Destination X coordinate |
| dst_y | input | COORD_W | Destination Y coordinate |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_ports | output | 5 | Allowed ports: [0] N, [1] E, [2] S, [3] W, [4] local |

## Verification
The assertions assume that coordinates and the traffic-class flag are stable and meaningful whenever `req_valid` is high. They compare the result against the configuration word that the request was sampled with, so they assume no other path alters that word between the sampling edge and the result. The bench drives every input only at falling edges, idles the request line while loading a word except in one deliberate same-edge case, and sweeps a 4x4 grid of both coordinate pairs under several words. This keeps the stimulus within in-range coordinates on a fixed-size mesh.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int NUM_DIR = 4;
  localparam int NUM_PORT = NUM_DIR + 1;
  localparam int TURN_W = 2 * NUM_DIR;
  localparam int CFG_W = TURN_W + 2 * NUM_DIR;

  typedef enum logic [2:0] {
    PORT_N = 3'd0,
    PORT_E = 3'd1,
    PORT_S = 3'd2,
    PORT_W = 3'd3,
    PORT_L = 3'd4
  } port_idx_e;

  typedef struct packed {
    logic [NUM_DIR-1:0] conn_glb;
    logic [NUM_DIR-1:0] conn_loc;
    logic [TURN_W-1:0]  turn;
  } route_cfg_t;
endpackage

// File: rtl/mrt_cfg_reg.sv
module mrt_cfg_reg import mrt_pkg::*; #(
  parameter logic [CFG_W-1:0] RESET_CFG = 16'hFFCC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output route_cfg_t       cfg
);
  always_ff @(posedge clk) begin
    if (rst) cfg <= route_cfg_t'(RESET_CFG);
    else if (we) cfg <= route_cfg_t'(wdata);
  end
endmodule

// File: rtl/mrt_dir_flags.sv
module mrt_dir_flags import mrt_pkg::*; #(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [NUM_DIR-1:0] toward,
  output logic               arrived
);
  always_comb begin
    toward[PORT_N] = dst_y > cur_y;
    toward[PORT_E] = dst_x > cur_x;
    toward[PORT_S] = dst_y < cur_y;
    toward[PORT_W] = dst_x < cur_x;
    arrived        = (dst_x == cur_x) && (dst_y == cur_y);
  end
endmodule

// File: rtl/mrt_port_select.sv
module mrt_port_select import mrt_pkg::*; (
  input  logic [NUM_DIR-1:0]  toward,
  input  logic                arrived,
  input  logic [TURN_W-1:0]   turn,
  input  logic [NUM_DIR-1:0]  conn,
  output logic [NUM_PORT-1:0] ports
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam int PA = (d % 2 == 0) ? 1 : 0;
    localparam int PB = PA + 2;
    logic straight, via_a, via_b;
    assign straight = toward[d] & ~toward[PA] & ~toward[PB];
    assign via_a    = toward[d] & toward[PA] & turn[2*d];
    assign via_b    = toward[d] & toward[PB] & turn[2*d+1];
    assign ports[d] = conn[d] & (straight | via_a | via_b);
  end
  assign ports[PORT_L] = arrived;
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit import mrt_pkg::*; #(
  parameter int COORD_W = 4,
  parameter logic [CFG_W-1:0] RESET_CFG = 16'hFFCC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                req_valid,
  input  logic                req_global,
  input  logic [COORD_W-1:0]  cur_x,
  input  logic [COORD_W-1:0]  cur_y,
  input  logic [COORD_W-1:0]  dst_x,
  input  logic [COORD_W-1:0]  dst_y,
  output logic                rsp_valid,
  output logic [NUM_PORT-1:0] rsp_ports
);
  route_cfg_t          cfg_q;
  logic [NUM_DIR-1:0]  toward;
  logic                arrived;
  logic [NUM_DIR-1:0]  conn_sel;
  logic [NUM_PORT-1:0] ports_c;

  mrt_cfg_reg #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg_q)
  );

  mrt_dir_flags #(.COORD_W(COORD_W)) u_dir (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .toward(toward), .arrived(arrived)
  );

  assign conn_sel = req_global ? cfg_q.conn_glb : cfg_q.conn_loc;

  mrt_port_select u_sel (
    .toward(toward), .arrived(arrived), .turn(cfg_q.turn),
    .conn(conn_sel), .ports(ports_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ports <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ports <= req_valid ? ports_c : '0;
    end
  end
endmodule

// File: rtl/mrt_checker.sv
module mrt_checker import mrt_pkg::*; #(
  parameter int COORD_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_global,
  input logic [COORD_W-1:0]  cur_x,
  input logic [COORD_W-1:0]  cur_y,
  input logic [COORD_W-1:0]  dst_x,
  input logic [COORD_W-1:0]  dst_y,
  input route_cfg_t          cfg_q,
  input logic                rsp_valid,
  input logic [NUM_PORT-1:0] rsp_ports
);
  logic [NUM_DIR-1:0] mask_now;
  assign mask_now = req_global ? cfg_q.conn_glb : cfg_q.conn_loc;

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2
  AST_ARRIVAL_LOCAL: assert property (@(posedge clk) disable iff (rst)
    req_valid && dst_x == cur_x && dst_y == cur_y |=> rsp_ports == 5'b10000); // R3
  AST_STRAIGHT_NORTH: assert property (@(posedge clk) disable iff (rst)
    req_valid && dst_x == cur_x && dst_y > cur_y |=> (rsp_ports & 5'b11110) == 5'b0); // R4
  AST_AT_MOST_TWO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(rsp_ports) <= 2); // R5
  AST_N_TURN: assert property (@(posedge clk) disable iff (rst)
    req_valid && dst_x != cur_x && !(dst_x > cur_x ? cfg_q.turn[0] : cfg_q.turn[1])
    |=> !rsp_ports[0]); // R5
  AST_E_TURN: assert property (@(posedge clk) disable iff (rst)
    req_valid && dst_y != cur_y && !(dst_y > cur_y ? cfg_q.turn[2] : cfg_q.turn[3])
    |=> !rsp_ports[1]); // R5
  AST_S_TURN: assert property (@(posedge clk) disable iff (rst)
    req_valid && dst_x != cur_x && !(dst_x > cur_x ? cfg_q.turn[4] : cfg_q.turn[5])
    |=> !rsp_ports[2]); // R5
  AST_W_TURN: assert property (@(posedge clk) disable iff (rst)
    req_valid && dst_y != cur_y && !(dst_y > cur_y ? cfg_q.turn[6] : cfg_q.turn[7])
    |=> !rsp_ports[3]); // R5
  AST_FENCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_ports[3:0] & ~$past(mask_now)) == 4'b0); // R6 R7
endmodule

bind mesh_route_unit mrt_checker #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_global(req_global),
  .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
  .cfg_q(cfg_q), .rsp_valid(rsp_valid), .rsp_ports(rsp_ports)
);

// File: tb/tb_mesh_route_unit.sv
`timescale 1ns/1ps
module tb_mesh_route_unit;
  localparam int CW = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_global = 1'b0;
  logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
  logic rsp_valid;
  logic [4:0] rsp_ports;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] model_cfg = 16'hFFCC;
  logic [4:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  mesh_route_unit #(.COORD_W(CW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_global(req_global),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .rsp_valid(rsp_valid), .rsp_ports(rsp_ports)
  );

  // Expected result built per quadrant from the requirement text
  function automatic logic [4:0] model(logic [15:0] w, logic g,
      int cx, int cy, int dx, int dy);
    logic [3:0] c;
    logic [7:0] t;
    logic [4:0] r;
    c = g ? w[15:12] : w[11:8];
    t = w[7:0];
    r = '0;
    if (dx == cx && dy == cy) r = 5'b10000;
    else if (dx == cx) begin
      if (dy > cy) r[0] = c[0]; else r[2] = c[2];
    end else if (dy == cy) begin
      if (dx > cx) r[1] = c[1]; else r[3] = c[3];
    end else if (dy > cy && dx > cx) begin
      r[0] = t[0] & c[0]; r[1] = t[2] & c[1];
    end else if (dy > cy) begin
      r[0] = t[1] & c[0]; r[3] = t[6] & c[3];
    end else if (dx > cx) begin
      r[2] = t[4] & c[2]; r[1] = t[3] & c[1];
    end else begin
      r[2] = t[5] & c[2]; r[3] = t[7] & c[3];
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [4:0] act, logic [4:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send(int cx, int cy, int dx, int dy, bit g, string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b1; req_global = g;
    cur_x = CW'(cx); cur_y = CW'(cy); dst_x = CW'(dx); dst_y = CW'(dy);
    exp_q.push_back(model(model_cfg, g, cx, cy, dx, dy));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
    end
  endtask

  task automatic load(logic [15:0] w);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    model_cfg = w;
  endtask

  task automatic sweep(string tag);
    for (int cx = 0; cx < 4; cx++)
      for (int cy = 0; cy < 4; cy++)
        for (int dx = 0; dx < 4; dx++)
          for (int dy = 0; dy < 4; dy++) begin
            send(cx, cy, dx, dy, 1'b0, tag);
            send(cx, cy, dx, dy, 1'b1, tag);
          end
    idle(3);
  endtask

  // Monitor: pops one expected item per presented result
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected result", rsp_ports, 5'b0);
        else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_ports === e, t, rsp_ports, e);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rsp_valid === 1'b0, "R1 reset valid", {4'b0, rsp_valid}, 5'b0);
    check(rsp_ports === 5'b0, "R1 reset ports", rsp_ports, 5'b0);
    rst = 1'b0;
    idle(3);
    check(rsp_valid === 1'b0 && exp_q.size() == 0, "R2 idle no result",
          {4'b0, rsp_valid}, 5'b0);

    // Default word: X-first permissions, all connected (R1)
    send(2, 2, 2, 2, 1'b0, "R3 arrival local");
    send(2, 2, 2, 3, 1'b0, "R4 straight north");
    send(2, 2, 3, 2, 1'b0, "R4 straight east");
    send(2, 2, 2, 0, 1'b0, "R4 straight south");
    send(2, 2, 0, 2, 1'b0, "R4 straight west");
    send(1, 1, 3, 3, 1'b0, "R1 default NE takes east");
    send(1, 1, 0, 3, 1'b0, "R1 default NW takes west");
    send(1, 1, 3, 0, 1'b0, "R5 default SE takes east");
    send(1, 1, 0, 0, 1'b0, "R5 default SW takes west");
    idle(3);

    load(16'hFF33); // Y-first permissions
    send(1, 1, 3, 3, 1'b0, "R5 yfirst NE takes north");
    send(1, 1, 0, 0, 1'b0, "R5 yfirst SW takes south");
    idle(2);

    load(16'hFFFF); // all turns allowed
    send(1, 1, 3, 3, 1'b0, "R5 adaptive NE two ports");
    send(3, 3, 0, 0, 1'b0, "R5 adaptive SW two ports");
    idle(2);

    load(16'hF5FF); // local mask N,S only; global all
    send(1, 1, 3, 3, 1'b0, "R6 fenced NE local north only");
    send(1, 1, 3, 1, 1'b0, "R6 fenced east local empty");
    send(1, 1, 3, 1, 1'b1, "R7 global east crosses fence");
    send(1, 1, 0, 3, 1'b1, "R7 global NW two ports");
    send(1, 1, 1, 1, 1'b0, "R3 fenced arrival local");
    idle(2);

    // Same-edge write: request uses old word (R8)
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 16'hFFCC;
    req_valid = 1'b1; req_global = 1'b0;
    cur_x = 4'd1; cur_y = 4'd1; dst_x = 4'd3; dst_y = 4'd1;
    exp_q.push_back(model(model_cfg, 1'b0, 1, 1, 3, 1));
    tag_q.push_back("R8 same-edge uses old word");
    model_cfg = 16'hFFCC;
    send(1, 1, 3, 1, 1'b0, "R8 next edge uses new word");
    idle(3);

    sweep("R5 sweep xfirst");
    load(16'hFF33); sweep("R5 sweep yfirst");
    load(16'hA5FF); sweep("R6 sweep fenced");
    load(16'h3C96); sweep("R7 sweep mixed masks");

    idle(4);
    check(exp_q.size() == 0, "R2 every request answered",
          5'(exp_q.size()), 5'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule